// File: doc/BRIEF.md
# Windowed Decision-Feedback Convolutional Decoder

This block decodes a hard-decision, rate-1/2 convolutional code with constraint length 3 (generator taps 111 and 101) one information bit at a time. Received 2-bit symbols enter a small shift buffer through a valid/ready handshake. When the buffer holds a full window, the block runs one add-compare-select step per buffered symbol over all trellis states in parallel. The tree always starts from a single known encoder state. Each node carries only an accumulated Hamming metric and a one-bit tag, which records the first information bit that the surviving path hypothesised.

After the last step, a minimum-metric selection over the live nodes picks a winner, and the winner's tag becomes the decoded bit. That bit is shifted into the known start state for the next decision. The next accepted symbol then slides the window along by one. No survivor history is stored and nothing is traced back. Ties are broken toward the lower predecessor index in compare-select and toward the lower state index in the final selection. To decode N bits, the upstream logic supplies the N code symbols plus enough trailing symbols (for example, an encoded zero tail) to fill the last window.

Top module: `mfd_decoder`

## Requirements
- R1: Out of reset `symReady` is 1. `symReady` is 0 whenever a decision is in progress. A symbol is taken only in a cycle where both `symValid` and `symReady` are high, so a symbol held on the input while `symReady` is low is neither lost nor taken twice.
- R2: Once the buffer holds STEPS = W-K symbols (12 with the defaults), `bitValid` pulses high for exactly one cycle. The pulse comes 13 rising edges after the edge that accepted the last symbol of the window, and `symReady` is high again in that same cycle.
- R3: The code is defined as follows. `symData[1]` is the parity of input bit, previous bit and the bit before that. `symData[0]` is the parity of input bit and the bit before the previous one. The encoder starts in the all-zero state after reset. For an error-free stream, the decoded bits equal the information bits in order.
- R4: A stream of N+STEPS-1 symbols yields exactly N decoded bits, with no further output.
- R5: A single flipped symbol bit inside any window does not change any decoded bit.
- R6: Each decided bit becomes the newest bit of the known start state used by the next decision. This is checked on streams with long runs of ones and on alternating patterns.
- R7: An active-low reset at any time clears the buffer, the metrics and the start state. A new stream after reset decodes correctly from the zero state.
- R8: Accumulated metrics stay within 2*STEPS. Any received pattern, including worst-case mismatched symbols, produces one bit per window without hanging.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| symValid | input | 1 | Received symbol is valid |
| symData | input | 2 | Received hard-decision symbol (bit 1 from taps 111, bit 0 from taps 101) |
| symReady | output | 1 | Block can accept a symbol this cycle |
| bitValid | output | 1 | One-cycle strobe: decoded bit is present |
| bitData | output | 1 | Decoded information bit |

## Verification
Two events can fall in the same cycle. In one cycle, a decision is emitted and the start state is updated by that same decision. In the next cycles, the refill handshake reopens while an upstream symbol has been held pending through the busy period. The bench provokes this by holding `symValid` high for the whole run of add-compare-select steps. It then requires the pending symbol to be taken exactly once, on the first cycle with `symReady` high. The decoded stream is judged against the information bits. A duplicated or dropped symbol, or a start state that misses the fed-back bit, corrupts every later decision. Such a fault shows up as a mismatch against the known sequence.

// File: rtl/mfd_pkg.sv
package mfd_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic push;    // accept a symbol into the window buffer
    logic init;    // first step: tree grows from the known start state
    logic step;    // perform one state-parallel ACS step
    logic decide;  // winner-take-all and feed the bit back
  } ctrl_t;

  typedef enum logic [1:0] {
    PH_FILL   = 2'd0,
    PH_RUN    = 2'd1,
    PH_DECIDE = 2'd2
  } phase_t;

endpackage

// File: rtl/mfd_ctrl.sv
module mfd_ctrl
  import mfd_pkg::*;
#(
  parameter int STEPS = 12
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       symValid,
  output logic                       symReady,
  output ctrl_t                      ctrl,
  output logic [$clog2(STEPS)-1:0]   stepIdx
);
  localparam int CW = $clog2(STEPS + 1);
  localparam int IW = $clog2(STEPS);

  phase_t        phase;
  logic [CW-1:0] fillCnt;
  logic [IW-1:0] stepCnt;

  assign symReady    = (phase == PH_FILL);
  assign ctrl.push   = symValid && symReady;
  assign ctrl.step   = (phase == PH_RUN);
  assign ctrl.init   = (phase == PH_RUN) && (stepCnt == '0);
  assign ctrl.decide = (phase == PH_DECIDE);
  assign stepIdx     = stepCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_FILL;
      fillCnt <= '0;
      stepCnt <= '0;
    end else begin
      unique case (phase)
        PH_FILL: if (ctrl.push) begin
          fillCnt <= fillCnt + 1'b1;
          if (fillCnt == CW'(STEPS - 1)) begin
            phase   <= PH_RUN;
            stepCnt <= '0;
          end
        end
        PH_RUN: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == IW'(STEPS - 1)) phase <= PH_DECIDE;
        end
        PH_DECIDE: begin
          fillCnt <= fillCnt - 1'b1;
          phase   <= PH_FILL;
        end
        default: phase <= PH_FILL;
      endcase
    end
  end

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    fillCnt <= CW'(STEPS)); // R1
  AST_RUN_AFTER_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.push && fillCnt == CW'(STEPS - 1)) |=> (ctrl.init && !symReady)); // R2
  AST_SLIDE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.decide |=> (symReady && fillCnt == CW'(STEPS - 1))); // R4

endmodule

// File: rtl/mfd_datapath.sv
module mfd_datapath
  import mfd_pkg::*;
#(
  parameter int          K     = 3,
  parameter int          STEPS = 12,
  parameter logic [K-1:0] G0   = 3'b111,
  parameter logic [K-1:0] G1   = 3'b101
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrl_t                    ctrl,
  input  logic [$clog2(STEPS)-1:0] stepIdx,
  input  logic [1:0]               symData,
  output logic                     bitValid,
  output logic                     bitData
);
  localparam int M  = K - 1;
  localparam int NS = 1 << M;
  localparam int MW = $clog2(2 * STEPS + 1);

  logic [1:0]    symBuf [STEPS];
  logic [MW-1:0] metric [NS];
  logic [NS-1:0] metValid;
  logic [NS-1:0] tagBit;
  logic [M-1:0]  startState;

  logic [MW-1:0] prevMet  [NS];
  logic [NS-1:0] prevValid;
  logic [MW-1:0] nextMet  [NS];
  logic [NS-1:0] nextValid;
  logic [NS-1:0] nextTag;
  logic [1:0]    symCur;
  logic          winTag;

  function automatic logic [1:0] encOut(input logic [M-1:0] s, input logic u);
    logic [K-1:0] r;
    r = {u, s};
    return {^(r & G0), ^(r & G1)};
  endfunction

  function automatic logic [MW-1:0] hamDist(input logic [1:0] a, input logic [1:0] b);
    logic [1:0] d;
    d = a ^ b;
    return MW'(d[1]) + MW'(d[0]);
  endfunction

  // Symbol storage: newest enters at the top, oldest leaves at index 0
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < STEPS; i++) symBuf[i] <= '0;
    end else if (ctrl.push) begin
      for (int i = 0; i < STEPS - 1; i++) symBuf[i] <= symBuf[i + 1];
      symBuf[STEPS - 1] <= symData;
    end
  end

  assign symCur = symBuf[stepIdx];

  // Predecessor view: on the first step only the known state is alive
  always_comb begin
    for (int s = 0; s < NS; s++) begin
      prevValid[s] = ctrl.init ? (startState == M'(s)) : metValid[s];
      prevMet[s]   = ctrl.init ? '0 : metric[s];
    end
  end

  // State-parallel add-compare-select with first-bit tags
  for (genvar ns = 0; ns < NS; ns++) begin : g_acs
    localparam int   P0 = (ns * 2) % NS;
    localparam int   P1 = P0 + 1;
    localparam logic UB = (ns >= NS / 2);
    logic [MW-1:0] cand0, cand1;
    logic          pick1;
    assign cand0 = prevMet[P0] + hamDist(symCur, encOut(M'(P0), UB));
    assign cand1 = prevMet[P1] + hamDist(symCur, encOut(M'(P1), UB));
    assign pick1 = prevValid[P1] && (!prevValid[P0] || (cand1 < cand0));
    assign nextMet[ns]   = pick1 ? cand1 : cand0;
    assign nextValid[ns] = prevValid[P0] || prevValid[P1];
    assign nextTag[ns]   = ctrl.init ? UB : (pick1 ? tagBit[P1] : tagBit[P0]);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
      metValid[ns] |-> (metric[ns] <= MW'(2 * STEPS))); // R8
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NS; s++) metric[s] <= '0;
      metValid <= '0;
      tagBit   <= '0;
    end else if (ctrl.step) begin
      for (int s = 0; s < NS; s++) metric[s] <= nextMet[s];
      metValid <= nextValid;
      tagBit   <= nextTag;
    end
  end

  // Winner-take-all: lowest metric, lower state index on ties
  always_comb begin
    logic [MW-1:0] best;
    logic          found;
    best   = '0;
    found  = 1'b0;
    winTag = 1'b0;
    for (int s = 0; s < NS; s++) begin
      if (metValid[s] && (!found || metric[s] < best)) begin
        best   = metric[s];
        found  = 1'b1;
        winTag = tagBit[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startState <= '0;
      bitData    <= 1'b0;
      bitValid   <= 1'b0;
    end else begin
      bitValid <= ctrl.decide;
      if (ctrl.decide) begin
        bitData    <= winTag;
        startState <= {winTag, startState[M-1:1]};
      end
    end
  end

  AST_LIVE_NODE: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.decide |-> (metValid != '0)); // R4
  AST_FEEDBACK: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |-> (startState[M-1] == bitData)); // R6

endmodule

// File: rtl/mfd_decoder.sv
module mfd_decoder
  import mfd_pkg::*;
#(
  parameter int           K  = 3,
  parameter int           W  = 5 * K,
  parameter logic [K-1:0] G0 = 3'b111,
  parameter logic [K-1:0] G1 = 3'b101
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       symValid,
  input  logic [1:0] symData,
  output logic       symReady,
  output logic       bitValid,
  output logic       bitData
);
  localparam int STEPS = W - K;
  localparam int IW    = $clog2(STEPS);

  ctrl_t         ctrl;
  logic [IW-1:0] stepIdx;

  mfd_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .symValid (symValid),
    .symReady (symReady),
    .ctrl     (ctrl),
    .stepIdx  (stepIdx)
  );

  mfd_datapath #(.K(K), .STEPS(STEPS), .G0(G0), .G1(G1)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .stepIdx  (stepIdx),
    .symData  (symData),
    .bitValid (bitValid),
    .bitData  (bitData)
  );

  AST_OUT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |=> !bitValid); // R2
  AST_READY_ON_OUT: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |-> symReady); // R1

endmodule

// File: tb/tb_mfd_decoder.sv
module tb_mfd_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int STEPS      = 12;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       symValid = 1'b0;
  logic [1:0] symData = 2'b00;
  logic       symReady, bitValid, bitData;

  int total = 0;
  int bad   = 0;

  logic       info [0:255];
  logic [1:0] syms [0:511];
  logic       got  [0:1023];
  int         gotCnt = 0;

  mfd_decoder dut (
    .clk(clk), .rstN(rstN), .symValid(symValid), .symData(symData),
    .symReady(symReady), .bitValid(bitValid), .bitData(bitData)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    if (bitValid) begin
      got[gotCnt] = bitData;
      gotCnt = gotCnt + 1;
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; symValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // Pattern kinds: 0 lfsr, 1 all ones, 2 alternating
  task automatic buildStream(input int n, input int kind, input logic [7:0] seed);
    logic [7:0] x;
    logic a, b;
    x = seed; a = 1'b0; b = 1'b0;
    for (int i = 0; i < n + STEPS - 1; i++) begin
      logic u;
      if (i >= n) u = 1'b0;
      else if (kind == 1) u = 1'b1;
      else if (kind == 2) u = i[0];
      else begin
        u = x[7];
        x = {x[6:0], x[7] ^ x[5] ^ x[4] ^ x[3]};
      end
      if (i < n) info[i] = u;
      syms[i] = {u ^ a ^ b, u ^ b};
      b = a; a = u;
    end
  endtask

  task automatic pushSym(input logic [1:0] s);
    symValid = 1'b1; symData = s;
    while (!symReady) @(negedge clk);
    @(negedge clk);
    symValid = 1'b0;
  endtask

  task automatic waitOut(input int base, input int n);
    int guard;
    guard = 0;
    while (gotCnt - base < n && guard < 20 * (n + STEPS)) begin
      @(negedge clk); guard++;
    end
    repeat (40) @(negedge clk);
  endtask

  task automatic compareStream(input int base, input int n, input string req);
    int mism;
    mism = 0;
    check(gotCnt - base == n, "R4 output count", gotCnt - base, n);
    for (int i = 0; i < n; i++) if (got[base + i] !== info[i]) mism++;
    check(mism == 0, req, mism, 0);
  endtask

  task automatic testResetState();
    doReset();
    @(negedge clk);
    check(symReady === 1'b1, "R1 ready after reset", symReady, 1);
    check(bitValid === 1'b0, "R7 no output after reset", bitValid, 0);
  endtask

  task automatic testCleanStream(input int kind, input logic [7:0] seed, input string req);
    int base, n;
    n = 40;
    doReset();
    buildStream(n, kind, seed);
    base = gotCnt;
    for (int i = 0; i < n + STEPS - 1; i++) pushSym(syms[i]);
    waitOut(base, n);
    compareStream(base, n, req);
  endtask

  task automatic testSingleErrors();
    int base, n;
    n = 60;
    doReset();
    buildStream(n, 0, 8'h3c);
    for (int i = 3; i < n; i += 20) syms[i] = syms[i] ^ ((i % 40 == 3) ? 2'b10 : 2'b01);
    base = gotCnt;
    for (int i = 0; i < n + STEPS - 1; i++) pushSym(syms[i]);
    waitOut(base, n);
    compareStream(base, n, "R5 single error corrected");
  endtask

  // Hold valid during the busy period: symbol must be taken exactly once
  task automatic testLatencyAndHold();
    int base, n, lat;
    n = 20;
    doReset();
    buildStream(n, 0, 8'h91);
    base = gotCnt;
    for (int i = 0; i < STEPS - 1; i++) pushSym(syms[i]);
    symValid = 1'b1; symData = syms[STEPS - 1];
    @(posedge clk);
    @(negedge clk);
    check(symReady === 1'b0, "R1 ready low while deciding", symReady, 0);
    symData = syms[STEPS];
    lat = 1;
    while (!bitValid && lat < 40) begin
      @(posedge clk); lat++;
      @(negedge clk);
    end
    lat--;
    check(lat == 13, "R2 decision latency", lat, 13);
    check(symReady === 1'b1, "R2 ready with output", symReady, 1);
    @(negedge clk);
    symValid = 1'b0;
    check(bitValid === 1'b0, "R2 single cycle pulse", bitValid, 0);
    for (int i = STEPS + 1; i < n + STEPS - 1; i++) begin
      symValid = 1'b1; symData = syms[i];
      repeat (3) @(negedge clk);
      while (!symReady) @(negedge clk);
      @(negedge clk);
      symValid = 1'b0;
    end
    waitOut(base, n);
    compareStream(base, n, "R1 held symbol taken once");
  endtask

  task automatic testMidReset();
    doReset();
    buildStream(20, 1, 8'h01);
    for (int i = 0; i < 16; i++) pushSym(syms[i]);
    testCleanStream(0, 8'h5a, "R7 decode after mid-stream reset");
  endtask

  task automatic testWorstMetrics();
    int base, n;
    n = 30;
    doReset();
    base = gotCnt;
    for (int i = 0; i < n + STEPS - 1; i++) pushSym((i % 3 == 0) ? 2'b11 : 2'b10);
    waitOut(base, n);
    check(gotCnt - base == n, "R8 one bit per window on hostile input", gotCnt - base, n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", total, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    testResetState();
    testCleanStream(0, 8'ha7, "R3 error-free decode");
    testCleanStream(1, 8'h00, "R6 feedback with ones");
    testCleanStream(2, 8'h00, "R6 feedback alternating");
    testSingleErrors();
    testLatencyAndHold();
    testMidReset();
    testWorstMetrics();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule